// File: doc/BRIEF.md
# Programmable Baud Clock Generator with Divide-by-16 Prescaler

This block turns a free-running internal clock enable into a slower baud clock enable for a UART-style channel. The baud enable usually runs at sixteen times the serial bit rate. A single 32-bit configuration word sets all three controls: a run enable, an optional fixed divide-by-16 prescaler, and a 12-bit divisor field `N` that divides by `N+1`. The prescaler is there for slow rates that the 12-bit divisor cannot reach by itself.

Each incoming tick passes through the prescaler when it is selected, and directly otherwise. The resulting stage ticks drive a 12-bit down counter. Each time that counter sits at zero and takes a stage tick, it reloads from `N` and fires a one-clock output pulse. The block has no streaming data path, so every pin is a plain control or status signal and no back-pressure applies.

A configuration write is a single-cycle strobe that carries the whole word. It is applied at the clock edge on which the strobe is sampled.

Top module: `brg_top`

## Requirements
- R1: After reset the generator is disabled and `baud_tick` is low. No pulse appears until a write sets the run enable.
- R2: The divisor `N` is taken from `cfg_wdata[12:1]`. The generator divides the stage ticks by `N+1`: `N=0` gives a pulse on every stage tick and `N=4095` gives one pulse every 4096 stage ticks.
- R3: When `cfg_wdata[0]` is set, input ticks are first divided by 16. With the prescaler on, the period is `16*(N+1)` input ticks and the first pulse after a start comes on the 16th tick. With the prescaler off, every input tick is a stage tick.
- R4: Bit 16 is the run enable. While it is clear, `baud_tick` stays low and both counters are held at zero. Because of this, a later enable starts from a clean phase: the first pulse comes on the first stage tick.
- R5: `baud_tick` is one clock wide and registered. It is high in the cycle after the `tick_in` cycle that completes a period, and a cycle with `tick_in` low is never followed by a pulse.
- R6: A new `N` written while the generator runs leaves the period in progress untouched. The new value is loaded only at the next terminal count.
- R7: Writing bit 17 as 1 clears both counters at that edge and suppresses any pulse for that cycle; the bit itself is not kept. The next pulse then follows the same start rule as in R3.
- R8: A write cycle does not use the value it carries. A `tick_in` that arrives in a write cycle is handled under the configuration in force before the write, unless that write also sets bit 17.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Internal clock enable to be divided |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: bit 0 prescaler, bits 12:1 divisor, bit 16 enable, bit 17 counter clear |
| baud_tick | output | 1 | One-cycle baud clock enable pulse |

## Verification
Every result is due exactly one clock after its cause. A pulse appears in the cycle after the completing `tick_in`, and a configuration write, an enable change or a clear acts at the edge of its strobe, so that its effect on the pulse train shows from the next cycle on. The bench drives inputs and samples `baud_tick` at the falling edge, one full cycle after driving. It compares the sample with a model that counts the input ticks remaining until the next pulse, which is a different formulation from the two cascaded counters in the design. Writes in the bench carry no tick, so the model applies each configuration cleanly. Long runs at `N=4095` and at the prescaled rate check the period boundaries over whole periods.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int unsigned CFG_W   = 32;
  localparam int unsigned PRE_POS = 0;
  localparam int unsigned DIV_LSB = 1;
  localparam int unsigned EN_POS  = 16;
  localparam int unsigned CLR_POS = 17;
endpackage

// File: rtl/brg_cfg_reg.sv
module brg_cfg_reg
  import brg_pkg::*;
#(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic             en,
  output logic             pre_sel,
  output logic [DIV_W-1:0] div_n,
  output logic             clr
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      pre_sel <= 1'b0;
      div_n   <= '0;
    end else if (we) begin
      en      <= wdata[EN_POS];
      pre_sel <= wdata[PRE_POS];
      div_n   <= wdata[DIV_LSB +: DIV_W];
    end
  end

  assign clr = we & wdata[CLR_POS];
endmodule

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             pre_sel,
  input  logic             tick_in,
  output logic             stage_tick,
  output logic [PRE_W-1:0] cnt
);
  localparam logic [PRE_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || clr || !pre_sel) begin
      cnt <= '0;
    end else if (tick_in) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign stage_tick = en & ~clr & tick_in & (~pre_sel | (cnt == LAST));
endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             step,
  input  logic [DIV_W-1:0] div_n,
  output logic [DIV_W-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= (cnt == '0) ? div_n : cnt - 1'b1;
    end
  end

  assign wrap = step & (cnt == '0);
endmodule

// File: rtl/brg_top.sv
module brg_top
  import brg_pkg::*;
#(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             baud_tick
);
  localparam int unsigned PCW = (PRE_W > 0) ? PRE_W : 1;

  logic             cfg_en;
  logic             cfg_pre;
  logic [DIV_W-1:0] cfg_div;
  logic             cfg_clr;
  logic             stage_tick;
  logic [PCW-1:0]   pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             div_wrap;

  brg_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .en(cfg_en), .pre_sel(cfg_pre), .div_n(cfg_div), .clr(cfg_clr)
  );

  generate
    if (PRE_W > 0) begin : g_pre
      brg_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .clr(cfg_clr),
        .pre_sel(cfg_pre), .tick_in(tick_in),
        .stage_tick(stage_tick), .cnt(pre_cnt)
      );
    end else begin : g_nopre
      assign pre_cnt    = '0;
      assign stage_tick = cfg_en & ~cfg_clr & tick_in;
    end
  endgenerate

  brg_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .clr(cfg_clr),
    .step(stage_tick), .div_n(cfg_div), .cnt(div_cnt), .wrap(div_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) baud_tick <= 1'b0;
    else        baud_tick <= div_wrap;
  end
endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned PCW   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_in,
  input logic             clr_req,
  input logic             en_q,
  input logic [DIV_W-1:0] div_n,
  input logic [PCW-1:0]   pre_cnt,
  input logic [DIV_W-1:0] div_cnt,
  input logic             baud_tick
);
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !baud_tick);

  a_r4_counts_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (pre_cnt == '0 && div_cnt == '0));

  a_r5_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_in |=> !baud_tick);

  a_r5_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && $past(div_n) != '0) |=> !baud_tick);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (pre_cnt == '0 && div_cnt == '0 && !baud_tick));
endmodule

bind brg_top brg_checker #(.DIV_W(DIV_W), .PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
  .clr_req(cfg_we & cfg_wdata[brg_pkg::CLR_POS]),
  .en_q(cfg_en), .div_n(cfg_div), .pre_cnt(pre_cnt),
  .div_cnt(div_cnt), .baud_tick(baud_tick)
);

// File: tb/tb_brg_top.sv
module tb_brg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        baud_tick;

  brg_top dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .baud_tick(baud_tick)
  );

  always #10ns clk = ~clk;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  // reference: ticks still needed before the next pulse
  bit  m_en = 0, m_pre = 0;
  int  m_div = 0, m_left = 1;
  bit  exp_tick = 0;

  function automatic logic [31:0] cfg(bit en, bit pre, int n, bit clr);
    logic [31:0] w;
    w = '0;
    w[0]    = pre;
    w[12:1] = n[11:0];
    w[16]   = en;
    w[17]   = clr;
    return w;
  endfunction

  function automatic int start_left(bit pre);
    return pre ? 16 : 1;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: baud_tick=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge; the result is sampled one cycle later
  task automatic step(bit we, logic [31:0] d, bit tk, string tag);
    cfg_we = we; cfg_wdata = d; tick_in = tk;
    if (we) begin
      if (d[17] || !m_en || !d[16]) m_left = start_left(d[0]);
      m_en = d[16]; m_pre = d[0]; m_div = int'(d[12:1]);
      exp_tick = 0;
    end else if (tk && m_en) begin
      m_left--;
      exp_tick = (m_left == 0);
      if (m_left == 0) m_left = (m_pre ? 16 : 1) * (m_div + 1);
    end else begin
      exp_tick = 0;
    end
    @(negedge clk);
    check(tag, baud_tick, exp_tick);
  endtask

  task automatic run(int n, int pct, string tag);
    for (int i = 0; i < n; i++)
      step(0, '0, (($urandom % 100) < pct), tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", baud_tick, 1'b0);
    run(20, 100, "R1");                        // no enable yet

    step(1, cfg(0, 0, 3, 0), 0, "R4");          // disabled: ticks ignored
    run(20, 100, "R4");

    step(1, cfg(1, 0, 0, 0), 0, "R2");          // N=0: every tick
    run(10, 100, "R2");
    step(1, cfg(1, 0, 2, 1), 0, "R5");          // gaps in tick_in
    run(60, 50, "R5");

    step(1, cfg(0, 0, 0, 0), 0, "R4");
    step(1, cfg(1, 0, 4095, 0), 0, "R2");       // longest divisor
    run(8200, 100, "R2");

    step(1, cfg(1, 1, 2, 1), 0, "R3");          // prescaled, period 48
    run(200, 100, "R3");

    step(1, cfg(1, 0, 9, 1), 0, "R6");
    run(5, 100, "R6");
    step(1, cfg(1, 0, 3, 0), 0, "R6");          // change mid-period
    run(30, 100, "R6");

    run(2, 100, "R7");
    step(1, cfg(1, 0, 5, 1), 0, "R7");          // clear mid-period
    run(30, 100, "R7");

    step(1, cfg(1, 0, 4, 1), 0, "R8");          // tick in a write cycle
    run(3, 100, "R8");
    cfg_we = 1; cfg_wdata = cfg(1, 0, 1, 0); tick_in = 1;
    // old N=4, count at 2 -> reaches 1, no pulse; N=1 is loaded later
    m_left--; m_div = 1; exp_tick = 0;
    @(negedge clk);
    check("R8", baud_tick, exp_tick);
    run(20, 100, "R8");

    for (int seg = 0; seg < 400; seg++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 10)
        step(1, cfg(m_en, m_pre, int'($urandom % 24), 0), 0, "R6");
      else if (r < 16)
        step(1, cfg(1, ($urandom % 4) == 0, int'($urandom % 16), 1), 0, "R7");
      else if (r < 19)
        step(1, cfg(0, 0, int'($urandom % 8), 0), 0, "R4");
      run(int'($urandom % 60) + 1, 70, "R5");
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule